// File: doc/BRIEF.md
# Enhanced Idle State Sequencer

This block takes package idle requests and orders operating-point changes around them. The idle levels are C1, C2 and C4. A request arrives as a one-cycle pulse that carries a level and a hint marking it as enhanced. A configuration bit can also promote every plain request to its enhanced form. For an enhanced request the block first steps the voltage/frequency point down to the lowest index, 0. It enters the idle state only after the regulator acknowledges that step. A plain request enters idle at once and sits at whatever point is current.

A break event releases activity at once. For an enhanced idle, the ramp back up runs while the package is already running again. The target of that ramp is the software point saved when the request was accepted. A second configuration bit enables hard deep-voltage operation. With it, an enhanced C4 parks in a deep-voltage state, and on exit the ramp targets the lowest point instead of the saved one. While the clocks are stopped (C2 or C4 idle), no regulator transaction may start. Outside idle, the block follows the software-requested point whenever the regulator link is free.

Top module: `idle_seq`

## Requirements
- R1: After reset, state_o is ACTIVE (0), run_o is 1, and vr_req, clk_gated and vr_deep are 0. State codes are ACTIVE=0, STEP_DOWN=1, IDLE=2, DEEP_VOLT=3, STEP_UP=4.
- R2: A request taken in ACTIVE or STEP_UP with req_hint=1 or cfg_promote=1 moves to STEP_DOWN on the next cycle. It issues target 0 and leaves STEP_DOWN only in the cycle the regulator acknowledges that target.
- R3: A request with req_hint=0 and cfg_promote=0 moves straight to IDLE on the next cycle with no regulator request. A break then returns to ACTIVE on the next cycle.
- R4: Level codes are 1=C1, 2=C2 and 3=C4. In IDLE or DEEP_VOLT, clk_gated is 1 for level 2 or 3 and 0 for level 1. vr_req never rises in the cycle after one with clk_gated=1.
- R5: A break in IDLE after an enhanced entry moves to STEP_UP on the next cycle with run_o=1. The block then requests the value sw_op had when the request was accepted, and returns to ACTIVE on the acknowledge.
- R6: When cfg_hard_deep=1, an enhanced level-3 request ends its step-down in DEEP_VOLT with vr_deep=1. A break there moves to STEP_UP, and the ramp targets point 0.
- R7: A break during STEP_DOWN lets the step-down finish. The block then moves to STEP_UP without entering IDLE and ramps to the saved point.
- R8: vr_req stays high with vr_target unchanged until vr_ack. After the acknowledge, vr_req is low for at least one cycle.
- R9: In ACTIVE, with no request outstanding and sw_op different from the last acknowledged point, the block requests sw_op.
- R10: A request accepted during STEP_UP is taken. For an enhanced request, the outstanding up-transaction completes first, and then target 0 is issued.
- R11: A request with level code 0, and a break in ACTIVE, have no effect on state or on the regulator port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Idle request strobe |
| req_lvl | input | 2 | Requested level: 1=C1, 2=C2, 3=C4, 0 ignored |
| req_hint | input | 1 | Per-request enhanced hint |
| cfg_promote | input | 1 | Promote every request to enhanced |
| cfg_hard_deep | input | 1 | Enable deep-voltage parking for enhanced C4 |
| brk_evt | input | 1 | Break event |
| sw_op | input | OPW | Software-requested operating point |
| vr_req | output | 1 | Regulator transaction request |
| vr_target | output | OPW | Requested operating point index |
| vr_ack | input | 1 | Regulator acknowledge, one cycle |
| vr_deep | output | 1 | Core voltage held at deep level |
| run_o | output | 1 | Package activity released |
| clk_gated | output | 1 | Clocks stopped |
| lvl_o | output | 2 | Level of the current or last idle |
| state_o | output | 3 | Sequencer state code |
| cur_op_o | output | OPW | Last acknowledged operating point |

## Verification
The bench builds the block with OPW=3 and a reset point of 7. This gives eight distinct points, so a saved point, a newer software point and the lowest point are always told apart. The bench's regulator model uses an acknowledge latency it varies from 1 to 6 cycles. That keeps a transaction open long enough to land a break inside a step-down, or a new request inside a ramp-up. It also lets hard deep-voltage parking be compared with plain C4 under the same stimulus.

// File: rtl/eis_pkg.sv
package eis_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_DOWN   = 3'd1,
    ST_IDLE   = 3'd2,
    ST_DEEP   = 3'd3,
    ST_UP     = 3'd4
  } seq_st_t;

  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_C1   = 2'd1,
    LV_C2   = 2'd2,
    LV_C4   = 2'd3
  } lvl_t;

  // enhanced when hinted or promoted by configuration
  function automatic logic is_enhanced(input logic hint, input logic promote);
    return hint | promote;
  endfunction

  // deep-voltage parking applies to enhanced C4 only
  function automatic logic parks_deep(input logic enh, input lvl_t lv, input logic hard);
    return enh & hard & (lv == LV_C4);
  endfunction

  // state reached once the step-down has been acknowledged
  function automatic seq_st_t rest_state(input logic deep);
    return deep ? ST_DEEP : ST_IDLE;
  endfunction

  // clocks are off in idle-type states at any level deeper than C1
  function automatic logic clocks_off(input seq_st_t s, input lvl_t lv);
    return ((s == ST_IDLE) || (s == ST_DEEP)) && (lv != LV_C1) && (lv != LV_NONE);
  endfunction

  function automatic logic releases_run(input seq_st_t s);
    return (s == ST_ACTIVE) || (s == ST_UP);
  endfunction

endpackage

// File: rtl/eis_req_dec.sv
module eis_req_dec
  import eis_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_lvl,
  input  logic       req_hint,
  input  logic       cfg_promote,
  input  logic       cfg_hard_deep,
  output logic       acc_valid,
  output lvl_t       acc_lvl,
  output logic       acc_enh,
  output logic       acc_deep
);

  always_comb begin
    acc_lvl   = lvl_t'(req_lvl);
    acc_valid = req_valid && (acc_lvl != LV_NONE);
    acc_enh   = is_enhanced(req_hint, cfg_promote);
    acc_deep  = parks_deep(acc_enh, acc_lvl, cfg_hard_deep);
  end

endmodule

// File: rtl/eis_oplink.sv
module eis_oplink #(
  parameter int unsigned     OPW    = 3,
  parameter logic [OPW-1:0]  RST_OP = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [OPW-1:0] issue_tgt,
  input  logic           vr_ack,
  output logic           vr_req,
  output logic [OPW-1:0] vr_target,
  output logic [OPW-1:0] cur_op,
  output logic           ready,
  output logic           done
);

  localparam logic [OPW-1:0] OP_LOW = '0;

  logic           req_q;
  logic [OPW-1:0] tgt_q;
  logic [OPW-1:0] cur_q;

  assign ready     = !req_q;
  assign done      = req_q && vr_ack;
  assign vr_req    = req_q;
  assign vr_target = tgt_q;
  assign cur_op    = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      tgt_q <= OP_LOW;
      cur_q <= RST_OP;
    end else if (done) begin
      req_q <= 1'b0;
      cur_q <= tgt_q;
    end else if (issue && ready) begin
      req_q <= 1'b1;
      tgt_q <= issue_tgt;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !vr_ack) |=> (req_q && $stable(tgt_q))); // R8
  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !req_q); // R8
  AST_ISSUE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ready); // R8

endmodule

// File: rtl/eis_fsm.sv
module eis_fsm
  import eis_pkg::*;
#(
  parameter int unsigned OPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  lvl_t           acc_lvl,
  input  logic           acc_enh,
  input  logic           acc_deep,
  input  logic           brk,
  input  logic [OPW-1:0] sw_op,
  input  logic [OPW-1:0] cur_op,
  input  logic           link_ready,
  input  logic           link_done,
  output seq_st_t        state,
  output lvl_t           lvl,
  output logic           issue,
  output logic [OPW-1:0] issue_tgt
);

  localparam logic [OPW-1:0] OP_LOW = '0;

  seq_st_t        st_q;
  lvl_t           lvl_q;
  logic           enh_q;
  logic           deep_q;
  logic           sent_q;
  logic           brk_pend_q;
  logic [OPW-1:0] saved_q;
  logic [OPW-1:0] up_tgt_q;

  // named internal events
  logic take_req;
  logic down_done;
  logic up_done;
  logic abandon;

  assign take_req  = acc_valid && releases_run(st_q);
  assign down_done = (st_q == ST_DOWN) && sent_q && link_done;
  assign up_done   = (st_q == ST_UP) && sent_q && link_done;
  assign abandon   = down_done && (brk_pend_q || brk);

  always_comb begin
    issue     = 1'b0;
    issue_tgt = OP_LOW;
    unique case (st_q)
      ST_ACTIVE: begin
        if (!take_req && link_ready && (sw_op != cur_op)) begin
          issue     = 1'b1;
          issue_tgt = sw_op;
        end
      end
      ST_DOWN: begin
        if (!sent_q && link_ready) begin
          issue     = 1'b1;
          issue_tgt = OP_LOW;
        end
      end
      ST_UP: begin
        if (!take_req && !sent_q && link_ready) begin
          issue     = 1'b1;
          issue_tgt = up_tgt_q;
        end
      end
      default: begin
        issue     = 1'b0;
        issue_tgt = OP_LOW;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_ACTIVE;
      lvl_q      <= LV_NONE;
      enh_q      <= 1'b0;
      deep_q     <= 1'b0;
      sent_q     <= 1'b0;
      brk_pend_q <= 1'b0;
      saved_q    <= OP_LOW;
      up_tgt_q   <= OP_LOW;
    end else if (take_req) begin
      lvl_q      <= acc_lvl;
      enh_q      <= acc_enh;
      deep_q     <= acc_deep;
      sent_q     <= 1'b0;
      brk_pend_q <= 1'b0;
      if (acc_enh) begin
        saved_q <= sw_op;
        st_q    <= ST_DOWN;
      end else begin
        st_q    <= ST_IDLE;
      end
    end else begin
      unique case (st_q)
        ST_ACTIVE: begin
          sent_q <= 1'b0;
        end
        ST_DOWN: begin
          if (issue) sent_q <= 1'b1;
          if (brk) brk_pend_q <= 1'b1;
          if (down_done) begin
            sent_q     <= 1'b0;
            brk_pend_q <= 1'b0;
            if (abandon) begin
              up_tgt_q <= saved_q;
              st_q     <= ST_UP;
            end else begin
              st_q <= rest_state(deep_q);
            end
          end
        end
        ST_IDLE: begin
          if (brk) begin
            sent_q <= 1'b0;
            if (enh_q) begin
              up_tgt_q <= saved_q;
              st_q     <= ST_UP;
            end else begin
              st_q <= ST_ACTIVE;
            end
          end
        end
        ST_DEEP: begin
          if (brk) begin
            sent_q   <= 1'b0;
            up_tgt_q <= OP_LOW;
            st_q     <= ST_UP;
          end
        end
        ST_UP: begin
          if (issue) sent_q <= 1'b1;
          if (up_done) begin
            sent_q <= 1'b0;
            st_q   <= ST_ACTIVE;
          end
        end
        default: st_q <= ST_ACTIVE;
      endcase
    end
  end

  assign state = st_q;
  assign lvl   = lvl_q;

  AST_IDLE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_DOWN && st_q != ST_DOWN && !$past(take_req)) |-> $past(link_done)); // R2
  AST_DEEP_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEEP) |-> (cur_op == OP_LOW)); // R6
  AST_ENH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && brk && enh_q) |=> (st_q == ST_UP)); // R5
  AST_PLAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !acc_enh) |=> (st_q == ST_IDLE)); // R3
  AST_BRK_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |=> (st_q == ST_UP)); // R7

endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import eis_pkg::*;
#(
  parameter int unsigned    OPW    = 3,
  parameter logic [OPW-1:0] RST_OP = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_lvl,
  input  logic           req_hint,
  input  logic           cfg_promote,
  input  logic           cfg_hard_deep,
  input  logic           brk_evt,
  input  logic [OPW-1:0] sw_op,
  output logic           vr_req,
  output logic [OPW-1:0] vr_target,
  input  logic           vr_ack,
  output logic           vr_deep,
  output logic           run_o,
  output logic           clk_gated,
  output logic [1:0]     lvl_o,
  output logic [2:0]     state_o,
  output logic [OPW-1:0] cur_op_o
);

  logic           acc_valid;
  lvl_t           acc_lvl;
  logic           acc_enh;
  logic           acc_deep;
  logic           issue;
  logic [OPW-1:0] issue_tgt;
  logic [OPW-1:0] cur_op;
  logic           link_ready;
  logic           link_done;
  seq_st_t        st;
  lvl_t           lvl;

  eis_req_dec u_dec (
    .req_valid     (req_valid),
    .req_lvl       (req_lvl),
    .req_hint      (req_hint),
    .cfg_promote   (cfg_promote),
    .cfg_hard_deep (cfg_hard_deep),
    .acc_valid     (acc_valid),
    .acc_lvl       (acc_lvl),
    .acc_enh       (acc_enh),
    .acc_deep      (acc_deep)
  );

  eis_oplink #(.OPW(OPW), .RST_OP(RST_OP)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .issue_tgt (issue_tgt),
    .vr_ack    (vr_ack),
    .vr_req    (vr_req),
    .vr_target (vr_target),
    .cur_op    (cur_op),
    .ready     (link_ready),
    .done      (link_done)
  );

  eis_fsm #(.OPW(OPW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_lvl    (acc_lvl),
    .acc_enh    (acc_enh),
    .acc_deep   (acc_deep),
    .brk        (brk_evt),
    .sw_op      (sw_op),
    .cur_op     (cur_op),
    .link_ready (link_ready),
    .link_done  (link_done),
    .state      (st),
    .lvl        (lvl),
    .issue      (issue),
    .issue_tgt  (issue_tgt)
  );

  assign clk_gated = clocks_off(st, lvl);
  assign vr_deep   = (st == ST_DEEP);
  assign run_o     = releases_run(st);
  assign lvl_o     = lvl;
  assign state_o   = st;
  assign cur_op_o  = cur_op;

  AST_NO_ISSUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vr_req) |-> !$past(clk_gated)); // R4
  AST_RUN_NOT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> !clk_gated); // R4
  AST_ACTIVE_BRK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && brk_evt && !acc_valid) |=> (st == ST_ACTIVE)); // R11

endmodule

// File: tb/sim_idle_seq.sv
`timescale 1ns/1ps
module sim_idle_seq;

  localparam int unsigned OPW = 3;
  localparam logic [OPW-1:0] RST_OP = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_lvl = 2'd0;
  logic req_hint = 1'b0;
  logic cfg_promote = 1'b0;
  logic cfg_hard_deep = 1'b0;
  logic brk_evt = 1'b0;
  logic [OPW-1:0] sw_op = RST_OP;
  logic vr_req;
  logic [OPW-1:0] vr_target;
  logic vr_ack = 1'b0;
  logic vr_deep, run_o, clk_gated;
  logic [1:0] lvl_o;
  logic [2:0] state_o;
  logic [OPW-1:0] cur_op_o;

  int n_chk = 0;
  int n_bad = 0;
  int lat = 2;
  int ack_cnt = 0;
  logic [OPW-1:0] vr_point = RST_OP;
  int hold_viol = 0;
  int gate_viol = 0;
  logic hold_exp = 1'b0, gap_exp = 1'b0, prev_gated = 1'b0, prev_req = 1'b0;
  logic [OPW-1:0] hold_tgt = '0;

  always #2.5 clk = ~clk;

  idle_seq #(.OPW(OPW), .RST_OP(RST_OP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lvl(req_lvl),
    .req_hint(req_hint), .cfg_promote(cfg_promote), .cfg_hard_deep(cfg_hard_deep),
    .brk_evt(brk_evt), .sw_op(sw_op), .vr_req(vr_req), .vr_target(vr_target),
    .vr_ack(vr_ack), .vr_deep(vr_deep), .run_o(run_o), .clk_gated(clk_gated),
    .lvl_o(lvl_o), .state_o(state_o), .cur_op_o(cur_op_o)
  );

  // regulator model
  always @(negedge clk) begin
    if (vr_ack) begin
      vr_ack <= 1'b0;
      ack_cnt <= 0;
    end else if (vr_req) begin
      if (ack_cnt + 1 >= lat) vr_ack <= 1'b1;
      else ack_cnt <= ack_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n && vr_req && vr_ack) vr_point <= vr_target;
    hold_exp <= rst_n && vr_req && !vr_ack;
    gap_exp  <= rst_n && vr_req && vr_ack;
    hold_tgt <= vr_target;
  end

  // R8 handshake and R4 gated-issue monitors
  always @(negedge clk) begin
    if (hold_exp && (!vr_req || vr_target != hold_tgt)) hold_viol++;
    if (gap_exp && vr_req) hold_viol++;
    if (rst_n && vr_req && !prev_req && prev_gated) gate_viol++;
    prev_req   <= vr_req;
    prev_gated <= clk_gated;
  end

  function automatic int exp_rest(input bit enh, input int lv, input bit hard);
    return (enh && hard && lv == 3) ? 3 : 2;
  endfunction

  function automatic int exp_up(input bit enh, input int lv, input bit hard, input int saved);
    return (enh && hard && lv == 3) ? 0 : saved;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_req(input int lv, input bit hint);
    req_valid = 1'b1; req_lvl = lv[1:0]; req_hint = hint;
    @(negedge clk);
    req_valid = 1'b0; req_hint = 1'b0;
  endtask

  task automatic send_brk();
    brk_evt = 1'b1;
    @(negedge clk);
    brk_evt = 1'b0;
  endtask

  task automatic wait_req_hi();
    for (int i = 0; i < 100 && !vr_req; i++) @(negedge clk);
  endtask

  task automatic wait_leave(input int s);
    for (int i = 0; i < 100 && state_o == s[2:0]; i++) @(negedge clk);
  endtask

  task automatic settle();
    for (int i = 0; i < 200 && !(state_o == 3'd0 && !vr_req && vr_point == sw_op); i++)
      @(negedge clk);
    tick(1);
  endtask

  initial begin
    int saved;
    int quiet;
    void'($urandom(32'd2024));
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 run", run_o, 1);
    chk("R1 vr_req", vr_req, 0);
    chk("R1 gated", clk_gated, 0);
    chk("R1 deep", vr_deep, 0);

    // R11 ignored stimulus
    send_req(0, 1);
    chk("R11 lvl0 state", state_o, 0);
    send_brk();
    tick(1);
    chk("R11 brk active state", state_o, 0);
    chk("R11 brk active vr_req", vr_req, 0);

    // R9 tracking
    sw_op = 3'd3;
    tick(1);
    chk("R9 req", vr_req, 1);
    chk("R9 target", vr_target, 3);
    settle();
    chk("R9 point", cur_op_o, 3);

    // R2 + R5 enhanced entry and wake
    sw_op = 3'd5;
    settle();
    send_req(2, 1);
    chk("R2 step_down", state_o, 1);
    wait_req_hi();
    chk("R2 target low", vr_target, 0);
    wait_leave(1);
    chk("R2 idle after ack", state_o, 2);
    chk("R2 point low", vr_point, 0);
    chk("R4 gated C2", clk_gated, 1);
    sw_op = 3'd2;
    send_brk();
    chk("R5 step_up", state_o, 4);
    chk("R5 run", run_o, 1);
    wait_req_hi();
    chk("R5 saved target", vr_target, 5);
    wait_leave(4);
    chk("R5 back active", state_o, 0);
    settle();
    chk("R9 after wake", cur_op_o, 2);

    // R3 plain idle
    send_req(2, 0);
    chk("R3 idle", state_o, 2);
    quiet = 0;
    for (int i = 0; i < 6; i++) begin
      if (vr_req) quiet++;
      tick(1);
    end
    chk("R3 no vr_req", quiet, 0);
    send_brk();
    chk("R3 back active", state_o, 0);
    // R4 C1 keeps clocks
    send_req(1, 0);
    chk("R4 C1 idle", state_o, 2);
    chk("R4 C1 not gated", clk_gated, 0);
    send_brk();

    // R6 hard deep-voltage via promotion
    cfg_hard_deep = 1'b1; cfg_promote = 1'b1;
    settle();
    send_req(3, 0);
    wait_leave(1);
    chk("R6 deep state", state_o, 3);
    chk("R6 vr_deep", vr_deep, 1);
    chk("R4 deep gated", clk_gated, 1);
    send_brk();
    chk("R6 step_up", state_o, 4);
    chk("R6 deep dropped", vr_deep, 0);
    wait_req_hi();
    chk("R6 exit low", vr_target, 0);
    wait_leave(4);
    cfg_hard_deep = 1'b0; cfg_promote = 1'b0;
    settle();

    // R7 break during step-down
    lat = 6;
    saved = sw_op;
    send_req(2, 1);
    wait_req_hi();
    send_brk();
    chk("R7 still down", state_o, 1);
    wait_leave(1);
    chk("R7 no idle", state_o, 4);
    wait_req_hi();
    chk("R7 ramp saved", vr_target, saved);
    wait_leave(4);
    settle();

    // R10 request during ramp-up
    lat = 4;
    saved = sw_op;
    send_req(2, 1);
    wait_leave(1);
    send_brk();
    wait_req_hi();
    chk("R10 up target", vr_target, saved);
    send_req(3, 1);
    chk("R10 back to down", state_o, 1);
    for (int i = 0; i < 100 && vr_req; i++) @(negedge clk);
    wait_req_hi();
    chk("R10 low after up", vr_target, 0);
    wait_leave(1);
    chk("R10 idle", state_o, 2);
    send_brk();
    wait_leave(4);
    settle();

    // randomized episodes
    for (int ep = 0; ep < 40; ep++) begin
      bit hint, prom, hard, enh;
      int lv, sv, st_exp;
      sv   = $urandom_range(0, 7);
      hint = 1'($urandom_range(0, 1));
      prom = 1'($urandom_range(0, 1));
      hard = 1'($urandom_range(0, 1));
      lv   = $urandom_range(1, 3);
      lat  = $urandom_range(1, 5);
      enh  = hint | prom;
      sw_op = sv[OPW-1:0];
      cfg_promote = prom; cfg_hard_deep = hard;
      settle();
      send_req(lv, hint);
      if (enh) wait_leave(1);
      st_exp = exp_rest(enh, lv, hard);
      chk("R2 rand rest state", state_o, st_exp);
      chk("R4 rand gated", clk_gated, (lv != 1) ? 1 : 0);
      chk("R6 rand deep", vr_deep, (st_exp == 3) ? 1 : 0);
      if (enh) chk("R2 rand low point", vr_point, 0);
      sw_op = 3'($urandom_range(0, 7));
      tick($urandom_range(0, 3));
      send_brk();
      chk("R5 rand wake state", state_o, enh ? 4 : 0);
      if (enh) begin
        wait_req_hi();
        chk("R5 rand up target", vr_target, exp_up(enh, lv, hard, sv));
        wait_leave(4);
      end
    end
    cfg_promote = 1'b0; cfg_hard_deep = 1'b0;
    settle();

    chk("R8 handshake violations", hold_viol, 0);
    chk("R4 issue while gated", gate_viol, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule